// File: doc/BRIEF.md
# Word-Addressed Program Counter Sequencer

This unit keeps the program counter of a single-cycle processor and produces the byte address used to fetch the next instruction. Every instruction is four bytes long, so the two low bits of a byte address are always zero. The unit therefore stores only the upper 30 bits as a word counter. On every rising clock edge the counter moves forward by one word. When the branch-taken input is high, it also adds the sign-extended 16-bit immediate as a word offset, with no shift. The fetch address output is the word counter with two zero bits appended below it.

A thin top connects two parts. A control part turns reset and the branch decision into a small set of strobes. A datapath part holds the counter and its adder. Jumps, exception vectors and the instruction memory itself sit outside this unit.

Top module: `pc_word_seq`

## Requirements
- R1: On a rising edge where `rst` is high, the counter loads zero, and `fetchAddr` reads 0x00000000 after that edge.
- R2: Bits [1:0] of `fetchAddr` are zero at all times after reset.
- R3: On a rising edge with `rst` low and `branchTaken` low, `fetchAddr` becomes its previous value plus 4.
- R4: On a rising edge with `rst` low and `branchTaken` high, `fetchAddr` becomes its previous value plus 4 plus (sign-extended `branchImm` shifted left by 2). `branchImm` is a two's-complement word count.
- R5: A `branchImm` with bit 15 set moves the address backwards. For example, 0xFFFF returns the address to the same instruction, and 0xFFFE returns it one instruction earlier.
- R6: Address arithmetic wraps modulo 2^32. Stepping past 0xFFFFFFFC gives 0x00000000, and a backward branch from 0x00000000 with 0xFFFE gives 0xFFFFFFFC.
- R7: When `branchTaken` is low, the value of `branchImm` has no effect on `fetchAddr`.
- R8: When `rst` and `branchTaken` are both high, reset wins and `fetchAddr` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| branchTaken | input | 1 | High when the current instruction's branch is taken |
| branchImm | input | 16 | Two's-complement branch offset in instructions |
| fetchAddr | output | 32 | Byte address of the instruction to fetch |

## Verification
The bench tests the sequencer against a byte-address model that adds 4 and, for taken branches, adds the immediate shifted left by two.

- Long runs of plain steps separate a correct one-word increment from a byte-sized or missing increment.
- Branches with small positive, small negative, maximum and minimum immediates show whether sign extension is missing, or whether the immediate was scaled twice.
- Random immediates mixed with taken and untaken cycles, with the immediate bus busy while the branch is not taken, show any leak of the offset into sequential steps.
- Runs across the top and bottom of the address space separate wrapping from saturation. Asserting reset together with a branch checks that reset has priority.

// File: rtl/pc_word_seq_pkg.sv
package pc_word_seq_pkg;

  // Strobes sent from the control part to the datapath each cycle.
  typedef struct packed {
    logic loadZero;   // clear the word counter
    logic addOffset;  // add the sign-extended immediate to the step
  } pcStrobes_t;

endpackage

// File: rtl/pc_word_ctrl.sv
module pc_word_ctrl
  import pc_word_seq_pkg::*;
(
  input  logic       rst,
  input  logic       branchTaken,
  output pcStrobes_t strobes
);

  // Reset takes priority over a taken branch.
  always_comb begin
    strobes.loadZero  = rst;
    strobes.addOffset = branchTaken & ~rst;
  end

endmodule

// File: rtl/pc_word_path.sv
module pc_word_path
  import pc_word_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  pcStrobes_t        strobes,
  input  logic [IMM_W-1:0]  branchImm,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int EXT_W  = WORD_W - IMM_W;

  logic [WORD_W-1:0] wordPc;
  logic [WORD_W-1:0] offsetWords;
  logic [WORD_W-1:0] seqWords;
  logic [WORD_W-1:0] nextWords;

  // The immediate is already a word count: sign-extend it, never shift it.
  always_comb begin
    if (strobes.addOffset)
      offsetWords = {{EXT_W{branchImm[IMM_W-1]}}, branchImm};
    else
      offsetWords = '0;
    seqWords  = wordPc + WORD_W'(1);
    nextWords = seqWords + offsetWords;   // wraps modulo 2^WORD_W
  end

  always_ff @(posedge clk) begin
    if (strobes.loadZero)
      wordPc <= '0;
    else
      wordPc <= nextWords;
  end

  assign fetchAddr = {wordPc, 2'b00};

endmodule

// File: rtl/pc_word_seq.sv
module pc_word_seq
  import pc_word_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branchTaken,
  input  logic [IMM_W-1:0]  branchImm,
  output logic [ADDR_W-1:0] fetchAddr
);

  pcStrobes_t strobes;

  pc_word_ctrl ctrl_i (
    .rst        (rst),
    .branchTaken(branchTaken),
    .strobes    (strobes)
  );

  pc_word_path #(
    .ADDR_W(ADDR_W),
    .IMM_W (IMM_W)
  ) path_i (
    .clk      (clk),
    .strobes  (strobes),
    .branchImm(branchImm),
    .fetchAddr(fetchAddr)
  );

endmodule

// File: rtl/pc_word_seq_chk.sv
module pc_word_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              branchTaken,
  input logic [IMM_W-1:0]  branchImm,
  input logic [ADDR_W-1:0] fetchAddr
);

  localparam int EXT_W = ADDR_W - IMM_W - 2;

  logic seenReset = 1'b0;
  always_ff @(posedge clk) if (rst) seenReset <= 1'b1;

  // Byte-domain step, built independently of the word datapath.
  logic [ADDR_W-1:0] byteStep;
  assign byteStep = branchTaken ? ({{EXT_W{branchImm[IMM_W-1]}}, branchImm, 2'b00} + ADDR_W'(4))
                                : ADDR_W'(4);

  assert_reset_zero_R1: assert property (@(posedge clk)
    disable iff (!seenReset)
    $past(rst) |-> fetchAddr == '0);

  assert_low_bits_R2: assert property (@(posedge clk)
    disable iff (rst || !seenReset)
    fetchAddr[1:0] == 2'b00);

  assert_seq_step_R3: assert property (@(posedge clk)
    disable iff (rst || !seenReset)
    !branchTaken |=> fetchAddr == $past(fetchAddr) + ADDR_W'(4));

  assert_branch_step_R4: assert property (@(posedge clk)
    disable iff (rst || !seenReset)
    branchTaken |=> fetchAddr == $past(fetchAddr) + $past(byteStep));

  assert_reset_wins_R8: assert property (@(posedge clk)
    (rst && branchTaken) |=> fetchAddr == '0);

endmodule

bind pc_word_seq pc_word_seq_chk #(
  .ADDR_W(ADDR_W),
  .IMM_W (IMM_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .branchTaken(branchTaken),
  .branchImm  (branchImm),
  .fetchAddr  (fetchAddr)
);

// File: tb/pc_word_seq_tb_top.sv
`timescale 1ns/1ps
module pc_word_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branchTaken = 1'b0;
  logic [15:0] branchImm = '0;
  logic [31:0] fetchAddr;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] refAddr = '0;

  always #5 clk = ~clk;

  pc_word_seq dut_i (
    .clk(clk), .rst(rst), .branchTaken(branchTaken),
    .branchImm(branchImm), .fetchAddr(fetchAddr)
  );

  task automatic check(input string req, input logic [31:0] expv);
    compared++;
    if (fetchAddr !== expv) begin
      mismatched++;
      $display("FAIL %s: fetchAddr=%h expected=%h", req, fetchAddr, expv);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, sample 2 ns later.
  task automatic step(input logic r, input logic tk, input logic [15:0] imm, input string req);
    rst = r; branchTaken = tk; branchImm = imm;
    @(posedge clk);
    if (r) refAddr = '0;
    else refAddr = refAddr + 32'd4 + (tk ? {{14{imm[15]}}, imm, 2'b00} : 32'd0);
    #2;
    check(req, refAddr);
    @(negedge clk);
  endtask

  task automatic testReset();                 // R1
    step(1'b1, 1'b0, 16'h0, "R1");
    step(1'b1, 1'b0, 16'h1234, "R1");
  endtask

  task automatic testSequential();            // R3, R2
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 16'h0, "R3");
    if (fetchAddr[1:0] !== 2'b00) begin mismatched++; $display("FAIL R2: low=%b expected=00", fetchAddr[1:0]); end
    compared++;
  endtask

  task automatic testBranches();              // R4, R5
    step(1'b0, 1'b1, 16'h0003, "R4");
    step(1'b0, 1'b1, 16'h7FFF, "R4");
    step(1'b0, 1'b1, 16'h8000, "R5");
    step(1'b0, 1'b1, 16'hFFFF, "R5");
    step(1'b0, 1'b1, 16'hFFFE, "R5");
  endtask

  task automatic testIgnoredImm();            // R7
    step(1'b0, 1'b0, 16'h7FFF, "R7");
    step(1'b0, 1'b0, 16'h8000, "R7");
    step(1'b0, 1'b0, 16'hA5A5, "R7");
  endtask

  task automatic testWrap();                  // R6
    step(1'b1, 1'b0, 16'h0, "R1");
    step(1'b0, 1'b1, 16'hFFFE, "R6");         // 0 -> FFFFFFFC
    step(1'b0, 1'b0, 16'h0, "R6");            // -> 00000000
    step(1'b0, 1'b1, 16'hFFFF, "R6");
  endtask

  task automatic testResetPriority();         // R8
    step(1'b0, 1'b0, 16'h0, "R3");
    step(1'b1, 1'b1, 16'h0040, "R8");
  endtask

  task automatic testRandom();                // R4, R5, R7
    for (int i = 0; i < 300; i++) begin
      logic [15:0] imm;
      logic tk;
      imm = 16'($urandom());
      tk = 1'($urandom());
      step(1'b0, tk, imm, tk ? "R4" : "R7");
    end
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    testReset();
    testSequential();
    testBranches();
    testIgnoredImm();
    testWrap();
    testResetPriority();
    testRandom();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule